// File: doc/BRIEF.md
# Quad Quasi-Bidirectional Port Block

This block holds four 8-bit general-purpose ports. Each port has an output latch that sits in a special-function register space. Every bit works on its own. A latch bit of 0 pulls its pin low. A latch bit of 1 releases the pin, so an outside source can drive it and the pin acts as an input. All latches come out of reset at all ones, which leaves every pin released.

Port 0 is open-drain and relies on an external pull-up resistor. Ports 1 to 3 enable an internal pull-up whenever they are not pulling low, so a pin left unconnected reads as 1. On port 3, each pin can also be pulled low by an alternate-function output, such as a serial transmitter or a memory strobe. The synchronized level of each port-3 pin is handed back to the alternate-function inputs: serial receive, the interrupt lines and the timer count inputs.

Pin levels pass through a two-flop synchronizer before they are read. A register read has a select. Read-modify-write operations set it and get the latch contents back. Plain reads clear it and get the synchronized pin levels.

Top module: `qbp_port_quad`

## Requirements
- R1: After reset, a latch read (bus_rd_latch=1) of every port returns FFh, pin_drive_low is all zero, and the synchronized pin state reads FFh.
- R2: The port registers decode at 80h (port 0), 90h (port 1), A0h (port 2) and B0h (port 3). A write with bus_we=1 to one of these addresses loads bus_wdata into that port's latch at the clock edge. The other latches keep their values.
- R3: On ports 0 to 2, pin_drive_low bit b of port k (vector bit 8k+b) is 1 exactly when latch bit b is 0.
- R4: pin_pullup_en is always 0 on port 0 (bits 7:0). On ports 1 to 3 it is 1 exactly when the pin is not being driven low.
- R5: A read with bus_rd_latch=1 returns the addressed latch. A read with bus_rd_latch=0 returns the synchronized pin levels, so a released pin that is forced low outside reads 0 on a pin read and 1 on a latch read.
- R6: A change on pin_in first appears on a pin read and on alt_in after exactly two rising clock edges.
- R7: Port 3 pin b (vector bit 24+b) is driven low when either its latch bit or alt_out bit b is 0.
- R8: alt_in bit b carries the synchronized level of port 3 pin b, whatever the latch holds.
- R9: A write to any address other than the four port addresses changes no latch. A read from such an address returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register address for read and write |
| bus_we | input | 1 | Write strobe, latched at the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rd_latch | input | 1 | 1: read the latch; 0: read the synchronized pins |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| pin_in | input | 32 | Pad levels, port k in bits 8k+7:8k |
| pin_drive_low | output | 32 | 1 turns on the pad pull-down transistor |
| pin_pullup_en | output | 32 | 1 turns on the internal pad pull-up |
| alt_out | input | 8 | Port 3 alternate-function outputs, 0 pulls the pin low |
| alt_in | output | 8 | Synchronized port 3 pin levels for alternate functions |

## Verification
A corrupted latch bit appears on pin_drive_low in the same cycle, because the pad logic has no register of its own. It also appears on the next latch read. A wrong synchronizer stage is caught by a plain read, which returns a stale or early pin level one cycle off the two-edge delay. The bench changes external forcing and waits exactly two edges to catch this. Faults in the address decode or the read select appear at once, as a latch read that disagrees with a pin read, or as nonzero data from an unmapped address.

// File: rtl/qbp_pkg.sv
// Shared constants and helpers for the quad quasi-bidirectional port block.
// Assumes ports sit at evenly spaced register addresses.
package qbp_pkg;
    localparam int unsigned PORT_W_DEF    = 8;
    localparam int unsigned NUM_PORTS_DEF = 4;
    localparam int unsigned ADDR_W_DEF    = 8;

    // Register address of port idx given base and stride.
    function automatic logic [ADDR_W_DEF-1:0] port_addr(
        input logic [ADDR_W_DEF-1:0] base,
        input logic [ADDR_W_DEF-1:0] stride,
        input int unsigned           idx);
        return base + ADDR_W_DEF'(idx) * stride;
    endfunction
endpackage

// File: rtl/qbp_latch_bank.sv
// One port output latch. Loads write data on a decoded write strobe.
// Resets to all ones, so every pin starts released.
// Assumes wr_en is already qualified by the address decode.
module qbp_latch_bank #(
    parameter int unsigned PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] latch_q
);
    // Latch register: reset to ones, load on write.
    always_ff @(posedge clk) begin
        if (!rst_n)     latch_q <= '1;
        else if (wr_en) latch_q <= wdata;
    end

    p_reset_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> latch_q == '1);
    p_write_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> latch_q == $past(wdata));
    p_hold_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(latch_q));
endmodule

// File: rtl/qbp_pin_sync.sv
// Multi-flop synchronizer for asynchronous pad levels.
// Resets to ones, the level of a released pulled-up pin.
// Assumes STAGES >= 1; the default of 2 gives a two-edge delay.
module qbp_pin_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    // Chain of flops, stage 0 samples the pads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) stage[i] <= '1;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];

    // Edges since reset release, saturating, used only to bound $past.
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (!rst_n)              age_q <= '0;
        else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
    end

    generate
        if (STAGES == 2) begin : g_chk2
            p_two_edge_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (age_q >= 2'd2) |-> q == $past(d, 2));
        end
    endgenerate
    p_reset_ones_sync_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> q == '1);
endmodule

// File: rtl/qbp_pad_ctrl.sv
// Pad control for one port: pull-down and pull-up enables from latch state.
// OPEN_DRAIN removes the internal pull-up; HAS_ALT merges alternate-function
// outputs (active low) into the pull-down. Purely combinational.
module qbp_pad_ctrl #(
    parameter int unsigned PORT_W     = 8,
    parameter bit          OPEN_DRAIN = 1'b0,
    parameter bit          HAS_ALT    = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] latch_q,
    input  logic [PORT_W-1:0] alt_out,
    output logic [PORT_W-1:0] drive_low,
    output logic [PORT_W-1:0] pullup_en
);
    logic [PORT_W-1:0] level;

    generate
        if (HAS_ALT) begin : g_alt
            // Effective level is low when latch or alternate output is low.
            assign level = latch_q & alt_out;
        end else begin : g_plain
            // Effective level follows the latch alone.
            assign level = latch_q;
        end
        if (OPEN_DRAIN) begin : g_od
            // Open drain: never pull up internally.
            assign pullup_en = '0;
        end else begin : g_qb
            // Quasi-bidirectional: pull up whenever released.
            assign pullup_en = level;
        end
    endgenerate

    // Pull-down whenever the effective level is zero.
    assign drive_low = ~level;

    generate
        for (genvar b = 0; b < int'(PORT_W); b++) begin : g_bit_chk
            p_latch_zero_pulls_r3: assert property (@(posedge clk) disable iff (!rst_n)
                !latch_q[b] |-> drive_low[b]);
            if (HAS_ALT) begin : g_alt_chk
                p_alt_zero_pulls_r7: assert property (@(posedge clk) disable iff (!rst_n)
                    !alt_out[b] |-> drive_low[b]);
                p_both_high_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
                    (latch_q[b] && alt_out[b]) |-> !drive_low[b]);
            end else begin : g_plain_chk
                p_high_releases_r3: assert property (@(posedge clk) disable iff (!rst_n)
                    latch_q[b] |-> !drive_low[b]);
            end
        end
    endgenerate
endmodule

// File: rtl/qbp_port_quad.sv
// Four quasi-bidirectional ports with latches in a register space.
// Decodes the port addresses, steers reads between latch and synchronized
// pins, and builds pad enables. Port 0 is open drain; ALT_PORT carries
// alternate-function overrides. Reads are combinational on bus_addr.
module qbp_port_quad
    import qbp_pkg::*;
#(
    parameter int unsigned        NUM_PORTS   = NUM_PORTS_DEF,
    parameter int unsigned        PORT_W      = PORT_W_DEF,
    parameter int unsigned        SYNC_STAGES = 2,
    parameter int unsigned        OD_PORT     = 0,
    parameter int unsigned        ALT_PORT    = 3,
    parameter logic [ADDR_W_DEF-1:0] BASE_ADDR   = 8'h80,
    parameter logic [ADDR_W_DEF-1:0] ADDR_STRIDE = 8'h10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W_DEF-1:0]       bus_addr,
    input  logic                        bus_we,
    input  logic [PORT_W-1:0]           bus_wdata,
    input  logic                        bus_rd_latch,
    output logic [PORT_W-1:0]           bus_rdata,
    input  logic [NUM_PORTS*PORT_W-1:0] pin_in,
    output logic [NUM_PORTS*PORT_W-1:0] pin_drive_low,
    output logic [NUM_PORTS*PORT_W-1:0] pin_pullup_en,
    input  logic [PORT_W-1:0]           alt_out,
    output logic [PORT_W-1:0]           alt_in
);
    localparam int unsigned TOT_W = NUM_PORTS * PORT_W;

    logic [NUM_PORTS-1:0] hit;
    logic [PORT_W-1:0]    latch_q [NUM_PORTS];
    logic [TOT_W-1:0]     pin_sync;

    qbp_pin_sync #(.W(TOT_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    generate
        for (genvar k = 0; k < int'(NUM_PORTS); k++) begin : g_port
            // Address match for port k.
            assign hit[k] = (bus_addr == port_addr(BASE_ADDR, ADDR_STRIDE, k));

            qbp_latch_bank #(.PORT_W(PORT_W)) latch_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (bus_we && hit[k]),
                .wdata   (bus_wdata),
                .latch_q (latch_q[k])
            );

            qbp_pad_ctrl #(
                .PORT_W     (PORT_W),
                .OPEN_DRAIN (k == int'(OD_PORT)),
                .HAS_ALT    (k == int'(ALT_PORT))
            ) pad_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .latch_q   (latch_q[k]),
                .alt_out   ((k == int'(ALT_PORT)) ? alt_out : {PORT_W{1'b1}}),
                .drive_low (pin_drive_low[k*PORT_W +: PORT_W]),
                .pullup_en (pin_pullup_en[k*PORT_W +: PORT_W])
            );
        end
    endgenerate

    // Read steering: latch for read-modify-write, synchronized pins otherwise.
    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < int'(NUM_PORTS); k++) begin
            if (hit[k]) bus_rdata = bus_rd_latch ? latch_q[k] : pin_sync[k*PORT_W +: PORT_W];
        end
    end

    // Alternate-function inputs see the synchronized pins of ALT_PORT.
    assign alt_in = pin_sync[ALT_PORT*PORT_W +: PORT_W];

    p_no_pull_fight_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_drive_low & pin_pullup_en) == '0);
    p_od_no_pullup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pin_pullup_en[OD_PORT*PORT_W +: PORT_W] == '0);
    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit == '0) |-> bus_rdata == '0);
    p_onehot_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
endmodule

// File: tb/qbp_port_quad_tb.sv
// Self-checking bench: models pads with external pull-ups and forcing,
// keeps its own latch model, and compares latch and pin reads.
module qbp_port_quad_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic        bus_rd_latch = 1'b0;
    logic [7:0]  bus_rdata;
    logic [31:0] pin_in;
    logic [31:0] pin_drive_low;
    logic [31:0] pin_pullup_en;
    logic [7:0]  alt_out = 8'hFF;
    logic [7:0]  alt_in;
    logic [31:0] ext_low = '0;

    int errors = 0;
    int checks = 0;
    logic [7:0] lat_m [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    // Pad model: every pin has a pull-up (internal or external); low if pulled.
    assign pin_in = ~(pin_drive_low | ext_low);

    qbp_port_quad dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rd_latch(bus_rd_latch), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_drive_low(pin_drive_low), .pin_pullup_en(pin_pullup_en),
        .alt_out(alt_out), .alt_in(alt_in)
    );

    function automatic logic [7:0] paddr(int k);
        return 8'h80 + 8'(k * 16);
    endfunction

    function automatic logic [31:0] exp_drive();
        logic [31:0] v;
        for (int k = 0; k < 4; k++) v[k*8 +: 8] = ~lat_m[k];
        v[31:24] = ~(lat_m[3] & alt_out);
        return v;
    endfunction

    function automatic logic [31:0] exp_pull();
        logic [31:0] v = ~exp_drive();
        v[7:0] = 8'h00;
        return v;
    endfunction

    function automatic logic [7:0] exp_pin(int k);
        logic [31:0] p = ~(exp_drive() | ext_low);
        return p[k*8 +: 8];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        for (int k = 0; k < 4; k++) if (a == paddr(k)) lat_m[k] = d;
    endtask

    task automatic rd(logic [7:0] a, logic sel, output logic [7:0] d);
        bus_addr = a; bus_rd_latch = sel;
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic check_all(string tag);
        logic [7:0] d;
        for (int k = 0; k < 4; k++) begin
            rd(paddr(k), 1'b1, d);
            check({tag, " R5 latch read"}, d, lat_m[k]);
            rd(paddr(k), 1'b0, d);
            check({tag, " R5 pin read"}, d, exp_pin(k));
        end
        check({tag, " R3 R7 drive"}, pin_drive_low, exp_drive());
        check({tag, " R4 pullup"}, pin_pullup_en, exp_pull());
        check({tag, " R8 alt_in"}, alt_in, exp_pin(3));
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [7:0] d;
        void'($urandom(32'h5EED_0451));
        for (int k = 0; k < 4; k++) lat_m[k] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        for (int k = 0; k < 4; k++) begin
            rd(paddr(k), 1'b1, d);
            check("R1 latch reset", d, 8'hFF);
            rd(paddr(k), 1'b0, d);
            check("R1 pin reset", d, 8'hFF);
        end
        check("R1 drive reset", pin_drive_low, 32'h0);

        // R2: each address loads only its own port
        wr(8'h90, 8'h3C);
        check("R2 port1 drive", pin_drive_low, exp_drive());
        rd(8'h80, 1'b1, d); check("R2 port0 untouched", d, 8'hFF);
        rd(8'h90, 1'b1, d); check("R2 port1 loaded", d, 8'h3C);
        wr(8'h80, 8'h55); wr(8'hA0, 8'h0F); wr(8'hB0, 8'hF0);
        settle();
        check_all("directed R2 R3");

        // R5: released pin forced low outside: latch 1, pin 0
        wr(8'hA0, 8'hFF);
        ext_low[16] = 1'b1;
        settle();
        rd(8'hA0, 1'b1, d); check("R5 forced latch read", d, 8'hFF);
        rd(8'hA0, 1'b0, d); check("R5 forced pin read", d, 8'hFE);
        // R4 on open-drain port with pin released
        check("R4 port0 no pullup", pin_pullup_en[7:0], 8'h00);

        // R6: exactly two edges of delay
        bus_addr = 8'hA0; bus_rd_latch = 1'b0;
        @(negedge clk);
        ext_low[17] = 1'b1;
        @(negedge clk);
        check("R6 one edge old", bus_rdata, 8'hFE);
        @(negedge clk);
        check("R6 two edges new", bus_rdata, 8'hFC);
        ext_low = '0;
        settle();

        // R7 R8: alternate output pulls port 3 low despite latch ones
        wr(8'hB0, 8'hFF);
        alt_out = 8'hFD;
        settle();
        check("R7 alt pulls low", pin_drive_low[31:24], 8'h02);
        rd(8'hB0, 1'b1, d); check("R7 latch stays", d, 8'hFF);
        check("R8 alt_in sees low", alt_in, 8'hFD);
        alt_out = 8'hFF;
        ext_low[31] = 1'b1;
        settle();
        check("R8 alt_in external", alt_in, 8'h7F);
        ext_low = '0;

        // R9: unmapped addresses
        wr(8'h81, 8'h00); wr(8'h00, 8'h00); wr(8'hC0, 8'h00);
        settle();
        check_all("R9 after unmapped writes");
        rd(8'h88, 1'b1, d); check("R9 unmapped read", d, 8'h00);
        rd(8'hC0, 1'b0, d); check("R9 unmapped pin read", d, 8'h00);

        // Random mix
        for (int it = 0; it < 60; it++) begin
            int k = int'($urandom_range(0, 3));
            wr(paddr(k), 8'($urandom));
            ext_low = $urandom;
            alt_out = 8'($urandom);
            settle();
            check_all("random R2 R3 R4 R5 R7 R8");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule